// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Host (separate address and data)

This block lets on-chip logic reach an external static memory, EEPROM or NOR flash over an asynchronous parallel bus. The address and data buses are separate. On the internal side it takes one request at a time. A request carries a direction, an address, write data and byte enables. The block answers every request with a one-cycle completion pulse, plus read data when the request was a read. On the external side it drives an active-low chip select, active-low read and write strobes, the address, optional active-low byte selects, and a data bus. The data bus is split into an output, an output enable and an input, so that a pad ring can join them into bidirectional pins.

Each access runs through four phases. First comes one setup clock with only the chip select low. Then the strobe is held low for two clocks, plus two more clocks for each wait state. Then one hold clock keeps the chip select low, and the chip select rises with the completion pulse. Reads and writes take their wait-state counts from separate configuration inputs. These counts are captured when the request is accepted. Between accesses the address, byte-select and write-data outputs keep their last values. In 16-bit mode a partial-width request is refused when byte selects are disabled.

Top module: `hostbus_sram_ctrl`

## Requirements
- R1: After reset, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, `bus_dq_oe`, `busy`, `done` and `err` are low, and `bus_bs_n` is all ones.
- R2: The chip select falls on the clock edge that accepts a request. The strobe of the access (`bus_rd_n` for a read, `bus_wr_n` for a write) falls exactly one clock later.
- R3: The strobe stays low for 2 + 2·W clocks. W is `cfg_rd_ws` for a read and `cfg_wr_ws` for a write.
- R4: The chip select stays low for exactly one clock after the strobe rises and then goes high. `done` is high for that first clock with the chip select high.
- R5: A read returns on `rd_data` the value that `bus_dq_i` carries on the last clock of the read strobe. `rd_data` is valid while `done` is high.
- R6: On a write, `bus_dq_oe` is high and `bus_dq_o` holds the write data from the setup clock through the hold clock. `bus_dq_oe` is never high while `bus_rd_n` is low.
- R7: While no access is running, `bus_addr`, `bus_bs_n` and `bus_dq_o` keep the values of the last access. A read leaves `bus_dq_o` unchanged.
- R8: `busy` is high from the clock after acceptance until `done`. A request presented while `busy` is high is ignored and does not start a bus access.
- R9: `bus_bs_n[i]` is low when byte lane i (`bus_dq_*[8i+7:8i]`) takes part in the access. With `cfg_bsel_en` set, `bus_bs_n` equals `~req_be`. With it clear, both bits are low. The byte selects change only when the address changes.
- R10: In 16-bit mode, when `cfg_bsel_en` is clear and `req_be` is not all ones, the request is refused. `done` and `err` are high on the clock after acceptance, and no bus signal changes.
- R11: The wait-state counts are captured at acceptance. A change to `cfg_rd_ws` or `cfg_wr_ws` during an access does not change that access.
- R12: `bus_rd_n` and `bus_wr_n` are never low together, and neither one is low while `bus_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_ws | input | WS_W | Read wait states (each adds 2 strobe clocks) |
| cfg_wr_ws | input | WS_W | Write wait states (each adds 2 strobe clocks) |
| cfg_bsel_en | input | 1 | Enable byte-select outputs and partial-width accesses |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit i = lane i |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (valid with `done`) |
| rd_data | output | DATA_W | Read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Address bus |
| bus_bs_n | output | DATA_W/8 | Byte selects, active low |
| bus_dq_o | output | DATA_W | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_i | input | DATA_W | Data bus input value |

## Verification
The hardest cases to reach from the ports involve a second stimulus arriving while an access is running. One is a request that overlaps a busy access. The other is a wait-state setting rewritten in the middle of a strobe. The bench holds a second request valid across the setup and strobe clocks, and it rewrites both wait-state inputs on the clock right after acceptance. It then counts chip-select-low clocks and strobe clocks to show that neither stimulus leaked in. The memory model drives `bus_dq_i` only while the read strobe is low, so a sample taken at the wrong clock returns zero instead of the stored word.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } hb_state_e;
endpackage

// File: rtl/hb_req_check.sv
// Decides whether a request must be refused: in a multi-lane bus a partial
// lane mask is only legal when byte selects are enabled.
module hb_req_check #(
  parameter int BE_W = 2
) (
  input  logic [BE_W-1:0] be,
  input  logic            bsel_en,
  output logic            refuse
);
  generate
    if (BE_W == 1) begin : g_narrow
      assign refuse = 1'b0;
    end else begin : g_wide
      assign refuse = !bsel_en && (be != {BE_W{1'b1}});
    end
  endgenerate
endmodule

// File: rtl/hb_seq.sv
// Phase sequencer: setup, stretched strobe, hold. Wait count latched at start.
module hb_seq
  import hb_pkg::*;
#(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_wr,
  input  logic [WS_W-1:0] rd_ws,
  input  logic [WS_W-1:0] wr_ws,
  output hb_state_e       state,
  output logic            cs_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            cap_en,
  output logic            in_hold
);
  localparam int CNT_W = WS_W + 1;

  hb_state_e        state_q;
  logic             wr_q;
  logic [WS_W-1:0]  ws_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n    <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      wr_q    <= 1'b0;
      ws_q    <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SETUP;
            cs_n    <= 1'b0;
            wr_q    <= start_wr;
            ws_q    <= start_wr ? wr_ws : rd_ws;
          end
        end
        ST_SETUP: begin
          state_q <= ST_STROBE;
          cnt_q   <= {ws_q, 1'b1};   // 2*W+1 down to 0 -> 2+2W clocks
          if (wr_q) wr_n <= 1'b0;
          else      rd_n <= 1'b0;
        end
        ST_STROBE: begin
          if (cnt_q == '0) begin
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            state_q <= ST_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: begin
          cs_n    <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign state   = state_q;
  assign cap_en  = (state_q == ST_STROBE) && (cnt_q == '0) && !wr_q;
  assign in_hold = (state_q == ST_HOLD);
endmodule

// File: rtl/hb_dpath.sv
// Address, byte-select and data registers; they only change on load or capture.
module hb_dpath #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  logic              bsel_en,
  input  logic              cap_en,
  input  logic              in_hold,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_bs_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      dq_o     <= '0;
      dq_oe    <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (load) begin
        bus_addr <= addr;
        if (load_wr) begin
          dq_o  <= wdata;
          dq_oe <= 1'b1;
        end
      end else if (in_hold) begin
        dq_oe <= 1'b0;
      end
      if (cap_en) rd_data <= dq_i;
    end
  end

  generate
    if (BE_W > 1) begin : g_bsel
      always_ff @(posedge clk) begin
        if (rst)       bus_bs_n <= '1;
        else if (load) bus_bs_n <= bsel_en ? ~be : '0;
      end
    end else begin : g_nobsel
      always_ff @(posedge clk) begin
        if (rst)       bus_bs_n <= '1;
        else if (load) bus_bs_n <= '0;
      end
    end
  endgenerate
endmodule

// File: rtl/hostbus_sram_ctrl.sv
// Asynchronous parallel memory host with separate address and data buses.
// DATA_W must be 8 or 16.
module hostbus_sram_ctrl
  import hb_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WS_W   = 4,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WS_W-1:0]   cfg_rd_ws,
  input  logic [WS_W-1:0]   cfg_wr_ws,
  input  logic              cfg_bsel_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_bs_n,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_i
);
  hb_state_e state;
  logic      refuse, accept, start, reject, cap_en, in_hold;

  assign busy   = (state != ST_IDLE);
  assign accept = req_valid && !busy;
  assign start  = accept && !refuse;
  assign reject = accept && refuse;

  hb_req_check #(.BE_W(BE_W)) u_check (
    .be      (req_be),
    .bsel_en (cfg_bsel_en),
    .refuse  (refuse)
  );

  hb_seq #(.WS_W(WS_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .start_wr (req_write),
    .rd_ws    (cfg_rd_ws),
    .wr_ws    (cfg_wr_ws),
    .state    (state),
    .cs_n     (bus_cs_n),
    .rd_n     (bus_rd_n),
    .wr_n     (bus_wr_n),
    .cap_en   (cap_en),
    .in_hold  (in_hold)
  );

  hb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_wr  (req_write),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .be       (req_be),
    .bsel_en  (cfg_bsel_en),
    .cap_en   (cap_en),
    .in_hold  (in_hold),
    .dq_i     (bus_dq_i),
    .bus_addr (bus_addr),
    .bus_bs_n (bus_bs_n),
    .dq_o     (bus_dq_o),
    .dq_oe    (bus_dq_oe),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= in_hold || reject;
      err  <= reject;
    end
  end
endmodule

// File: rtl/hb_ctrl_checker.sv
module hb_ctrl_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic              done,
  input logic              err,
  input logic              busy
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n)); // R12
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst) (!rd_n || !wr_n) |-> !cs_n); // R12
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst) !(dq_oe && !rd_n)); // R6
  AST_SETUP_GAP: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> (rd_n && wr_n)); // R2
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |=> (!rd_n || !wr_n)); // R2
  AST_HOLD_CS_LOW: assert property (@(posedge clk) disable iff (rst) ($rose(rd_n) || $rose(wr_n)) |-> !cs_n); // R4
  AST_HOLD_ONE: assert property (@(posedge clk) disable iff (rst) ($rose(rd_n) || $rose(wr_n)) |=> cs_n); // R4
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> done); // R4
  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (rst) (cs_n && $past(cs_n)) |-> $stable(addr)); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R8
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (rst) err |-> (done && cs_n)); // R10
endmodule

bind hostbus_sram_ctrl hb_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (bus_cs_n),
  .rd_n  (bus_rd_n),
  .wr_n  (bus_wr_n),
  .dq_oe (bus_dq_oe),
  .addr  (bus_addr),
  .done  (done),
  .err   (err),
  .busy  (busy)
);

// File: tb/sim_hostbus_sram_ctrl.sv
`timescale 1ns/1ps
module sim_hostbus_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_rd_ws = '0, cfg_wr_ws = '0;
  logic        cfg_bsel_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic        bus_cs_n, bus_rd_n, bus_wr_n, bus_dq_oe;
  logic [19:0] bus_addr;
  logic [1:0]  bus_bs_n;
  logic [15:0] bus_dq_o, bus_dq_i;

  logic [15:0] mem [16];
  int total = 0, bad = 0;

  int   m_setup, m_strobe, m_hold;
  logic m_done, m_err, m_busy1, m_ovl, m_excl, m_cs_after, m_oe_after;
  logic [15:0] m_rd, m_wdq;

  always #4 clk = ~clk;

  // memory model: drives data only while the read strobe is low
  assign bus_dq_i = !bus_rd_n ? mem[bus_addr[3:0]] : 16'h0000;

  hostbus_sram_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_rd_ws(cfg_rd_ws), .cfg_wr_ws(cfg_wr_ws),
    .cfg_bsel_en(cfg_bsel_en), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_addr(bus_addr), .bus_bs_n(bus_bs_n), .bus_dq_o(bus_dq_o),
    .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one access; records phase lengths seen at the bus
  task automatic access(input logic wr, input logic [19:0] a, input logic [15:0] wd,
                        input logic [1:0] be, input int ws_after);
    bit seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    if (ws_after >= 0) begin
      cfg_rd_ws = 4'(ws_after);
      cfg_wr_ws = 4'(ws_after);
    end
    m_busy1 = busy; m_setup = 0; m_strobe = 0; m_hold = 0;
    m_ovl = 0; m_excl = 0; m_wdq = '0;
    for (int i = 0; i < 200; i++) begin
      if (done) break;
      if (!bus_cs_n) begin
        if (!bus_rd_n || !bus_wr_n) begin m_strobe++; seen = 1; end
        else if (seen) m_hold++;
        else m_setup++;
      end
      if ((!bus_rd_n && !bus_wr_n) || (bus_cs_n && (!bus_rd_n || !bus_wr_n))) m_excl = 1;
      if (!bus_rd_n && bus_dq_oe) m_ovl = 1;
      if (!bus_wr_n && bus_dq_oe) begin
        m_wdq = bus_dq_o;
        for (int l = 0; l < 2; l++)
          if (!bus_bs_n[l]) mem[bus_addr[3:0]][l*8 +: 8] = bus_dq_o[l*8 +: 8];
      end
      @(negedge clk);
    end
    m_done = done; m_err = err; m_rd = rd_data;
    m_cs_after = bus_cs_n; m_oe_after = bus_dq_oe;
  endtask

  task automatic t_reset;
    chk(bus_cs_n && bus_rd_n && bus_wr_n, "R1 strobes idle", {bus_cs_n, bus_rd_n, bus_wr_n}, 3'b111);
    chk(!bus_dq_oe && !busy && !done && !err, "R1 flags low", {bus_dq_oe, busy, done, err}, 0);
    chk(bus_bs_n == 2'b11, "R1 byte selects", bus_bs_n, 2'b11);
  endtask

  task automatic t_read_basic;
    mem[2] = 16'h1234;
    cfg_rd_ws = 0; cfg_wr_ws = 5;
    access(1'b0, 20'h00002, 16'h0, 2'b11, -1);
    chk(m_setup == 1, "R2 setup clocks", m_setup, 1);
    chk(m_strobe == 2, "R3 read strobe ws0", m_strobe, 2);
    chk(m_hold == 1, "R4 hold clocks", m_hold, 1);
    chk(m_done && m_cs_after, "R4 done with cs high", {m_done, m_cs_after}, 2'b11);
    chk(m_rd == 16'h1234, "R5 read data", m_rd, 16'h1234);
    chk(m_busy1, "R8 busy after accept", m_busy1, 1);
    chk(!m_ovl, "R6 no drive during read", m_ovl, 0);
    chk(!m_excl, "R12 strobe exclusivity", m_excl, 0);
    chk(!m_err, "R10 no error on full word", m_err, 0);
  endtask

  task automatic t_read_wait;
    mem[4] = 16'hBEEF;
    cfg_rd_ws = 3; cfg_wr_ws = 0;
    access(1'b0, 20'h00004, 16'h0, 2'b11, -1);
    chk(m_strobe == 8, "R3 read strobe ws3", m_strobe, 8);
    chk(m_rd == 16'hBEEF, "R5 read data after waits", m_rd, 16'hBEEF);
  endtask

  task automatic t_write_wait;
    mem[6] = 16'h0000;
    cfg_wr_ws = 2; cfg_rd_ws = 3;
    access(1'b1, 20'h00006, 16'hCAFE, 2'b11, -1);
    chk(m_strobe == 6, "R3 write strobe ws2", m_strobe, 6);
    chk(m_wdq == 16'hCAFE, "R6 write data on bus", m_wdq, 16'hCAFE);
    chk(mem[6] == 16'hCAFE, "R6 word stored", mem[6], 16'hCAFE);
    chk(!m_oe_after, "R6 output enable released", m_oe_after, 0);
    chk(m_hold == 1 && m_setup == 1, "R4 write framing", {m_setup[3:0], m_hold[3:0]}, 8'h11);
  endtask

  task automatic t_idle_hold;
    repeat (4) @(negedge clk);
    chk(bus_addr == 20'h6 && bus_dq_o == 16'hCAFE, "R7 idle keeps write values", {bus_addr[11:0], bus_dq_o}, {12'h6, 16'hCAFE});
    chk(bus_bs_n == 2'b00, "R9 full word selects both lanes", bus_bs_n, 2'b00);
    cfg_rd_ws = 0;
    access(1'b0, 20'h00002, 16'h5A5A, 2'b11, -1);
    repeat (3) @(negedge clk);
    chk(bus_addr == 20'h2, "R7 idle keeps read address", bus_addr, 20'h2);
    chk(bus_dq_o == 16'hCAFE, "R7 read leaves write data", bus_dq_o, 16'hCAFE);
  endtask

  task automatic t_bsel;
    cfg_bsel_en = 1'b1; cfg_wr_ws = 0;
    mem[8] = 16'h0000;
    access(1'b1, 20'h00008, 16'h1122, 2'b01, -1);
    chk(!m_err && mem[8] == 16'h0022, "R9 low lane write", mem[8], 16'h0022);
    chk(bus_bs_n == 2'b10, "R9 low lane select", bus_bs_n, 2'b10);
    access(1'b1, 20'h00008, 16'hAABB, 2'b10, -1);
    chk(mem[8] == 16'hAA22, "R9 high lane write", mem[8], 16'hAA22);
    chk(bus_bs_n == 2'b01, "R9 high lane select", bus_bs_n, 2'b01);
  endtask

  task automatic t_reject;
    cfg_bsel_en = 1'b0;
    mem[9] = 16'h5555;
    access(1'b1, 20'h00009, 16'h0000, 2'b01, -1);
    chk(m_done && m_err, "R10 refused with err", {m_done, m_err}, 2'b11);
    chk(m_setup + m_strobe + m_hold == 0, "R10 no bus cycle", m_setup + m_strobe + m_hold, 0);
    chk(mem[9] == 16'h5555, "R10 memory untouched", mem[9], 16'h5555);
    chk(bus_addr == 20'h8 && bus_bs_n == 2'b01, "R10 bus outputs unchanged", {bus_addr[7:0], 6'b0, bus_bs_n}, {8'h08, 8'h01});
  endtask

  task automatic t_busy_ignore;
    int lows = 0;
    cfg_wr_ws = 0; cfg_bsel_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'hA; req_wdata = 16'h1111; req_be = 2'b11;
    @(negedge clk);
    req_addr = 20'hB; req_wdata = 16'h2222;
    for (int i = 0; i < 12; i++) begin
      if (i == 2) req_valid = 1'b0;
      if (!bus_cs_n) lows++;
      @(negedge clk);
    end
    chk(lows == 4, "R8 single access while busy", lows, 4);
    chk(bus_addr == 20'hA, "R8 second request ignored", bus_addr, 20'hA);
  endtask

  task automatic t_cfg_latch;
    cfg_rd_ws = 1; cfg_wr_ws = 1;
    mem[12] = 16'h7E57;
    access(1'b0, 20'h0000C, 16'h0, 2'b11, 3);
    chk(m_strobe == 4, "R11 wait count latched", m_strobe, 4);
    chk(m_rd == 16'h7E57, "R11 read data", m_rd, 16'h7E57);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_read_wait();
    t_write_wait();
    t_idle_hold();
    t_bsel();
    t_reject();
    t_busy_ignore();
    t_cfg_latch();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not complete act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule